// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block drives the control side of a raw NAND flash read. On a start pulse it issues a read opcode, a column address and a row address on a byte-wide write path, and on large pages a confirm opcode. It then waits for the device's ready/busy line and strobes out the page or spare-area contents one byte or one half-word at a time. Each item it reads appears on a registered output with a valid flag.

Three operations are selected by a 2-bit code: page read, spare-area read and bad-block check. The geometry is set per operation by configuration inputs, which are captured at start: small (512-byte) or large (2048-byte) pages, two or three row cycles, an 8- or 16-bit data bus, the spare-area size, pages per block and the position of the bad-block marker byte. A bad-block check reads the spare area of the block's first page and, if that page is clean, the spare area of its last page. A ready line that stays low for too long ends the operation with an error flag.

Top module: `nand_rd_seq`

## Requirements
- R1: A page read writes opcode 0x00 with nf_cle high, then a column address of zero: one address cycle for 512-byte pages and two for 2048-byte pages.
- R2: After the column cycles, the row address is written least significant byte first: bits 7:0, then 15:8, then bits 23:16 only when three row cycles are selected.
- R3: For page and spare reads the row address equals page + block × pages-per-block. For a bad-block check it is block × pages-per-block for the first page and that value + pages-per-block − 1 for the last page.
- R4: On 2048-byte pages opcode 0x30 is written with nf_cle high right after the last address cycle. On 512-byte pages no confirm is written.
- R5: A spare read (op code 1, and each page of a bad-block check) on 2048-byte pages uses opcode 0x00 with column 2048, sent as bytes 0x00 then 0x08, followed by the confirm. On 512-byte pages it uses opcode 0x50 with one column cycle of 0x00.
- R6: After the last command or address write, no read strobe is issued for at least GUARD_CYC cycles, and none is issued while nf_rb is low.
- R7: A read takes 512 or 2048 bytes for a page and cfg_spare_bytes for a spare read. In 8-bit mode there is one strobe per byte, and rd_data carries the byte in bits 7:0 with bits 15:8 zero. In 16-bit mode there are half as many strobes and rd_data is the full half-word. rd_valid is high for one cycle, one cycle after each strobe, in strobe order.
- R8: In a bad-block check the marker byte is the byte at cfg_mark_pos in 8-bit mode. In 16-bit mode it is the low byte (even position) or the high byte (odd position) of half-word cfg_mark_pos/2. If the marker is not 0xFF on the first page, bad_blk is set and the last page is not read. Otherwise the last page is checked the same way. rd_valid stays low throughout a check.
- R9: If nf_rb stays low for TIMEOUT_CYC cycles in the ready wait, tmo_err is set, done is pulsed and no read strobe follows.
- R10: After reset the block is idle with every output low. nf_cle and nf_ale are never high together, nf_we and nf_re are never high together, and no strobe occurs while idle.
- R11: start is ignored while busy is high, and a start with op code 3 is ignored.
- R12: done is a single-cycle pulse at the end of each operation. bad_blk and tmo_err keep their values until the next accepted start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse |
| op_sel | input | 2 | 0 page read, 1 spare read, 2 bad-block check, 3 no operation |
| blk_idx | input | BLK_W | Block number |
| pg_idx | input | PG_W | Page within block |
| cfg_large_pg | input | 1 | 1: 2048-byte pages, 0: 512-byte pages |
| cfg_row3 | input | 1 | 1: three row cycles, 0: two |
| cfg_bus16 | input | 1 | 1: 16-bit data bus |
| cfg_spare_bytes | input | SPARE_W | Spare-area size in bytes |
| cfg_pg_per_blk | input | PPB_W | Pages per block |
| cfg_mark_pos | input | MPOS_W | Byte offset of bad-block marker in spare area |
| busy | output | 1 | Operation in progress |
| done | output | 1 | End-of-operation pulse |
| bad_blk | output | 1 | Bad-block result |
| tmo_err | output | 1 | Ready wait expired |
| rd_valid | output | 1 | rd_data is valid |
| rd_data | output | 16 | Read byte or half-word |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we | output | 1 | Write strobe for command/address |
| nf_re | output | 1 | Read strobe |
| nf_io_out | output | 8 | Command or address byte |
| nf_io_in | input | 16 | Data from device |
| nf_rb | input | 1 | Ready (1) / busy (0) |

## Verification
The hardest case to reach is the bad-block check in 16-bit mode with an odd marker position. Only there does the byte lane inside the half-word decide the result, and only the last page can make the block bad. The bench places its device model's non-0xFF marker on the last page alone. It also runs a clean block at the same odd offset, so a wrong lane choice or a missing second-page pass shows up as a wrong verdict or as a command stream that does not match. The timeout is reached by having the model hold the ready line low well past TIMEOUT_CYC.

// File: rtl/nrs_pkg.sv
package nrs_pkg;

   typedef enum logic [1:0] {
      OP_PAGE   = 2'd0,
      OP_SPARE  = 2'd1,
      OP_BADCHK = 2'd2,
      OP_NONE   = 2'd3
   } nrs_op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CMD,
      S_ADDR,
      S_CONF,
      S_WAIT,
      S_XFER,
      S_FIN
   } nrs_state_e;

   localparam logic [7:0] CMD_READ    = 8'h00;
   localparam logic [7:0] CMD_CONFIRM = 8'h30;
   localparam logic [7:0] CMD_SPARE   = 8'h50;

   localparam int SMALL_PG = 512;
   localparam int LARGE_PG = 2048;

endpackage

// File: rtl/nrs_addr_gen.sv
module nrs_addr_gen #(
   parameter int ROW_W = 24
) (
   input  logic [2:0]       idx,
   input  logic             two_col,
   input  logic             three_row,
   input  logic [15:0]      col,
   input  logic [ROW_W-1:0] row,
   output logic [7:0]       abyte,
   output logic             last
);

   logic [23:0] row_x;
   logic [2:0]  ncol;
   logic [2:0]  nall;
   logic [2:0]  ridx;

   assign row_x = 24'(row);
   assign ncol  = two_col ? 3'd2 : 3'd1;
   assign nall  = ncol + (three_row ? 3'd3 : 3'd2);
   assign last  = (idx == nall - 3'd1);
   assign ridx  = idx - ncol;

   always_comb begin
      if (idx < ncol) begin
         abyte = idx[0] ? col[15:8] : col[7:0];
      end else begin
         case (ridx)
            3'd0:    abyte = row_x[7:0];
            3'd1:    abyte = row_x[15:8];
            default: abyte = row_x[23:16];
         endcase
      end
   end

endmodule

// File: rtl/nrs_ready_wait.sv
module nrs_ready_wait #(
   parameter int TIMEOUT_CYC = 4096,
   parameter int GUARD_CYC   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic rb,
   output logic go,
   output logic expired
);

   localparam int CW = $clog2(TIMEOUT_CYC + 1);

   logic [CW-1:0] cnt;
   logic          guard_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!arm) begin
         cnt <= '0;
      end else if (cnt != CW'(TIMEOUT_CYC - 1)) begin
         cnt <= cnt + CW'(1);
      end
   end

   generate
      if (GUARD_CYC == 0) begin : g_no_guard
         assign guard_ok = 1'b1;
      end else begin : g_guard
         assign guard_ok = (cnt >= CW'(GUARD_CYC));
      end
   endgenerate

   assign go      = arm && guard_ok && rb;
   assign expired = arm && !go && (cnt == CW'(TIMEOUT_CYC - 1));

endmodule

// File: rtl/nrs_mark_chk.sv
module nrs_mark_chk #(
   parameter int XCNT_W = 12,
   parameter int MPOS_W = 6
) (
   input  logic [XCNT_W-1:0] xcnt,
   input  logic [15:0]       din,
   input  logic [MPOS_W-1:0] mpos,
   input  logic              bus16,
   output logic              hit
);

   logic [XCNT_W-1:0] word_sel;
   logic [7:0]        lane;

   assign word_sel = bus16 ? XCNT_W'(mpos[MPOS_W-1:1]) : XCNT_W'(mpos);
   assign lane     = (bus16 && mpos[0]) ? din[15:8] : din[7:0];
   assign hit      = (xcnt == word_sel) && (lane != 8'hFF);

endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq
   import nrs_pkg::*;
#(
   parameter int BLK_W       = 16,
   parameter int PG_W        = 8,
   parameter int PPB_W       = 9,
   parameter int SPARE_W     = 7,
   parameter int MPOS_W      = 6,
   parameter int ROW_W       = 24,
   parameter int TIMEOUT_CYC = 4096,
   parameter int GUARD_CYC   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [1:0]         op_sel,
   input  logic [BLK_W-1:0]   blk_idx,
   input  logic [PG_W-1:0]    pg_idx,
   input  logic               cfg_large_pg,
   input  logic               cfg_row3,
   input  logic               cfg_bus16,
   input  logic [SPARE_W-1:0] cfg_spare_bytes,
   input  logic [PPB_W-1:0]   cfg_pg_per_blk,
   input  logic [MPOS_W-1:0]  cfg_mark_pos,
   output logic               busy,
   output logic               done,
   output logic               bad_blk,
   output logic               tmo_err,
   output logic               rd_valid,
   output logic [15:0]        rd_data,
   output logic               nf_cle,
   output logic               nf_ale,
   output logic               nf_we,
   output logic               nf_re,
   output logic [7:0]         nf_io_out,
   input  logic [15:0]        nf_io_in,
   input  logic               nf_rb
);

   localparam int XCNT_W = $clog2(LARGE_PG) + 1;
   localparam int PROD_W = BLK_W + PPB_W;

   generate
      if (ROW_W < 16 || ROW_W > 24) begin : g_chk_row
         $error("ROW_W must lie in 16..24");
      end
      if (GUARD_CYC >= TIMEOUT_CYC - 1) begin : g_chk_guard
         $error("GUARD_CYC must be below TIMEOUT_CYC-1");
      end
      if (MPOS_W < 2 || (1 << MPOS_W) > (1 << SPARE_W)) begin : g_chk_mpos
         $error("MPOS_W must be 2..SPARE_W");
      end
      if ((1 << SPARE_W) > LARGE_PG) begin : g_chk_spare
         $error("SPARE_W too wide");
      end
   endgenerate

   nrs_state_e         st;
   nrs_op_e            op_q;
   logic [BLK_W-1:0]   blk_q;
   logic [PG_W-1:0]    pg_q;
   logic               large_q;
   logic               row3_q;
   logic               bus16_q;
   logic [SPARE_W-1:0] spare_q;
   logic [PPB_W-1:0]   ppb_q;
   logic [MPOS_W-1:0]  mpos_q;
   logic               phase;
   logic [2:0]         aidx;
   logic [XCNT_W-1:0]  xcnt;
   logic               bad_q;
   logic               err_q;
   logic               rdv_q;
   logic [15:0]        rdd_q;

   logic               spare_op;
   logic [7:0]         cmd1;
   logic [15:0]        col;
   logic [PROD_W-1:0]  prod;
   logic [ROW_W-1:0]   blk_base;
   logic [ROW_W-1:0]   row_sel;
   logic [XCNT_W-1:0]  nbytes;
   logic [XCNT_W-1:0]  nxfer;
   logic               last_x;
   logic [7:0]         abyte;
   logic               alast;
   logic               rdy_go;
   logic               rdy_exp;
   logic               mark_hit;
   logic               chk_op;

   assign spare_op = (op_q != OP_PAGE);
   assign chk_op   = (op_q == OP_BADCHK);
   assign cmd1     = (spare_op && !large_q) ? CMD_SPARE : CMD_READ;
   assign col      = (spare_op && large_q) ? 16'(LARGE_PG) : 16'd0;
   assign prod     = PROD_W'(blk_q) * PROD_W'(ppb_q);
   assign blk_base = ROW_W'(prod);

   always_comb begin
      if (chk_op) begin
         row_sel = phase ? (blk_base + ROW_W'(ppb_q) - ROW_W'(1)) : blk_base;
      end else begin
         row_sel = blk_base + ROW_W'(pg_q);
      end
   end

   assign nbytes = spare_op ? XCNT_W'(spare_q)
                            : (large_q ? XCNT_W'(LARGE_PG) : XCNT_W'(SMALL_PG));
   assign nxfer  = bus16_q ? (nbytes >> 1) : nbytes;
   assign last_x = (xcnt == nxfer - XCNT_W'(1));

   nrs_addr_gen #(.ROW_W(ROW_W)) u_addr (
      .idx       (aidx),
      .two_col   (large_q),
      .three_row (row3_q),
      .col       (col),
      .row       (row_sel),
      .abyte     (abyte),
      .last      (alast)
   );

   nrs_ready_wait #(.TIMEOUT_CYC(TIMEOUT_CYC), .GUARD_CYC(GUARD_CYC)) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (st == S_WAIT),
      .rb      (nf_rb),
      .go      (rdy_go),
      .expired (rdy_exp)
   );

   nrs_mark_chk #(.XCNT_W(XCNT_W), .MPOS_W(MPOS_W)) u_mark (
      .xcnt  (xcnt),
      .din   (nf_io_in),
      .mpos  (mpos_q),
      .bus16 (bus16_q),
      .hit   (mark_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         op_q    <= OP_PAGE;
         blk_q   <= '0;
         pg_q    <= '0;
         large_q <= 1'b0;
         row3_q  <= 1'b0;
         bus16_q <= 1'b0;
         spare_q <= '0;
         ppb_q   <= '0;
         mpos_q  <= '0;
         phase   <= 1'b0;
         aidx    <= '0;
         xcnt    <= '0;
         bad_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         case (st)
            S_IDLE: begin
               if (start && (nrs_op_e'(op_sel) != OP_NONE)) begin
                  op_q    <= nrs_op_e'(op_sel);
                  blk_q   <= blk_idx;
                  pg_q    <= pg_idx;
                  large_q <= cfg_large_pg;
                  row3_q  <= cfg_row3;
                  bus16_q <= cfg_bus16;
                  spare_q <= cfg_spare_bytes;
                  ppb_q   <= cfg_pg_per_blk;
                  mpos_q  <= cfg_mark_pos;
                  phase   <= 1'b0;
                  bad_q   <= 1'b0;
                  err_q   <= 1'b0;
                  st      <= S_CMD;
               end
            end
            S_CMD: begin
               aidx <= '0;
               st   <= S_ADDR;
            end
            S_ADDR: begin
               if (alast) begin
                  st <= large_q ? S_CONF : S_WAIT;
               end else begin
                  aidx <= aidx + 3'd1;
               end
            end
            S_CONF: begin
               st <= S_WAIT;
            end
            S_WAIT: begin
               xcnt <= '0;
               if (rdy_go) begin
                  st <= S_XFER;
               end else if (rdy_exp) begin
                  err_q <= 1'b1;
                  st    <= S_FIN;
               end
            end
            S_XFER: begin
               xcnt <= xcnt + XCNT_W'(1);
               if (chk_op && mark_hit) begin
                  bad_q <= 1'b1;
               end
               if (last_x) begin
                  if (chk_op && !phase && !(bad_q || mark_hit)) begin
                     phase <= 1'b1;
                     st    <= S_CMD;
                  end else begin
                     st <= S_FIN;
                  end
               end
            end
            default: begin
               st <= S_IDLE;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdv_q <= 1'b0;
         rdd_q <= '0;
      end else begin
         rdv_q <= (st == S_XFER) && !chk_op;
         if (st == S_XFER) begin
            rdd_q <= bus16_q ? nf_io_in : {8'h00, nf_io_in[7:0]};
         end
      end
   end

   always_comb begin
      case (st)
         S_CMD:   nf_io_out = cmd1;
         S_CONF:  nf_io_out = CMD_CONFIRM;
         S_ADDR:  nf_io_out = abyte;
         default: nf_io_out = 8'h00;
      endcase
   end

   assign nf_cle   = (st == S_CMD) || (st == S_CONF);
   assign nf_ale   = (st == S_ADDR);
   assign nf_we    = nf_cle || nf_ale;
   assign nf_re    = (st == S_XFER);
   assign busy     = (st != S_IDLE);
   assign done     = (st == S_FIN);
   assign bad_blk  = bad_q;
   assign tmo_err  = err_q;
   assign rd_valid = rdv_q;
   assign rd_data  = rdd_q;

endmodule

// File: rtl/nrs_checker.sv
module nrs_checker (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic bad_blk,
   input logic tmo_err,
   input logic rd_valid,
   input logic nf_cle,
   input logic nf_ale,
   input logic nf_we,
   input logic nf_re,
   input logic nf_rb
);

   assert_bus_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(nf_we && nf_re) && !(nf_cle && nf_ale));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!nf_we && !nf_re));

   assert_read_after_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nf_re) |-> $past(nf_rb));

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_flags_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(bad_blk) && $stable(tmo_err)));

   assert_tmo_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_err |-> (!nf_re && !rd_valid));

   assert_busy_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

endmodule

bind nand_rd_seq nrs_checker u_nrs_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .bad_blk  (bad_blk),
   .tmo_err  (tmo_err),
   .rd_valid (rd_valid),
   .nf_cle   (nf_cle),
   .nf_ale   (nf_ale),
   .nf_we    (nf_we),
   .nf_re    (nf_re),
   .nf_rb    (nf_rb)
);

// File: tb/tb_nand_rd_seq.sv
module tb_nand_rd_seq;
   import nrs_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int TMO        = 200;
   localparam int GUARD      = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start;
   logic [1:0]  op_sel;
   logic [15:0] blk_idx;
   logic [7:0]  pg_idx;
   logic        c_large, c_row3, c_bus16;
   logic [6:0]  c_spare;
   logic [8:0]  c_ppb;
   logic [5:0]  c_mpos;
   logic        busy, done, bad_blk, tmo_err, rd_valid;
   logic [15:0] rd_data;
   logic        nf_cle, nf_ale, nf_we, nf_re, nf_rb;
   logic [7:0]  nf_io_out;
   logic [15:0] nf_io_in;

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_rd_seq #(.TIMEOUT_CYC(TMO), .GUARD_CYC(GUARD)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
      .blk_idx(blk_idx), .pg_idx(pg_idx),
      .cfg_large_pg(c_large), .cfg_row3(c_row3), .cfg_bus16(c_bus16),
      .cfg_spare_bytes(c_spare), .cfg_pg_per_blk(c_ppb), .cfg_mark_pos(c_mpos),
      .busy(busy), .done(done), .bad_blk(bad_blk), .tmo_err(tmo_err),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we(nf_we), .nf_re(nf_re),
      .nf_io_out(nf_io_out), .nf_io_in(nf_io_in), .nf_rb(nf_rb)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit finished = 0;

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // ---------------- device model ----------------
   logic [7:0] m_cmd = 8'h00;
   logic [7:0] m_abuf [0:4];
   int m_acnt = 0;
   int m_rc = 0;
   int busy_left = 0;
   int t_r = 4;
   int bad_r0 = -1;
   int bad_r1 = -1;

   initial for (int i = 0; i < 5; i++) m_abuf[i] = 8'h00;

   function automatic logic [7:0] byte_at(int row, bit sp, int off);
      if (sp && off == int'(c_mpos))
         return (row == bad_r0 || row == bad_r1) ? 8'h00 : 8'hFF;
      return 8'(row * 7 + off * 13 + (sp ? 85 : 0));
   endfunction

   function automatic bit is_bad(int row);
      return row == bad_r0 || row == bad_r1;
   endfunction

   assign nf_rb = (busy_left == 0);

   always @(posedge clk) begin
      if (nf_we) begin
         busy_left <= t_r;
         m_rc <= 0;
         if (nf_cle && nf_io_out != 8'h30) begin
            m_cmd  <= nf_io_out;
            m_acnt <= 0;
         end
         if (nf_ale) begin
            m_abuf[m_acnt] <= nf_io_out;
            m_acnt <= m_acnt + 1;
         end
      end else if (busy_left > 0) begin
         busy_left <= busy_left - 1;
      end
      if (nf_re) m_rc <= m_rc + 1;
   end

   always_comb begin
      int col, rs, row, off;
      bit sp;
      col = c_large ? int'({m_abuf[1], m_abuf[0]}) : 0;
      rs  = c_large ? 2 : 1;
      row = int'({c_row3 ? m_abuf[rs+2] : 8'h00, m_abuf[rs+1], m_abuf[rs]});
      sp  = (m_cmd == 8'h50) || (c_large && col >= 2048);
      off = (c_large && sp) ? col - 2048 : col;
      if (c_bus16)
         nf_io_in = {byte_at(row, sp, off + 2*m_rc + 1), byte_at(row, sp, off + 2*m_rc)};
      else
         nf_io_in = {8'hC3, byte_at(row, sp, off + m_rc)};
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      logic       cle;
      logic [7:0] b;
      string      tag;
   } wr_item_t;

   wr_item_t    wq[$];
   logic [15:0] dq[$];

   always @(negedge clk) begin
      if (rst_n && nf_we) begin
         if (wq.size() == 0) begin
            chk(0, "R11", "unexpected bus write", int'(nf_io_out), 0);
         end else begin
            wr_item_t e;
            e = wq.pop_front();
            chk(nf_cle == e.cle && nf_io_out == e.b, e.tag, "cmd/addr write",
                int'({nf_cle, nf_io_out}), int'({e.cle, e.b}));
         end
      end
      if (rst_n && nf_re && !nf_rb)
         chk(0, "R6", "read strobe while busy", 0, 1);
      if (rst_n && rd_valid) begin
         if (dq.size() == 0) begin
            chk(0, "R7", "unexpected data item", int'(rd_data), 0);
         end else begin
            logic [15:0] d;
            d = dq.pop_front();
            chk(rd_data == d, "R7", "read data", int'(rd_data), int'(d));
         end
      end
   end

   task automatic push_w(logic cle, logic [7:0] b, string tag);
      wr_item_t e;
      e.cle = cle; e.b = b; e.tag = tag;
      wq.push_back(e);
   endtask

   task automatic push_seq(int op, int row);
      bit sp;
      int col;
      string ct;
      sp  = (op != 0);
      col = (sp && c_large) ? 2048 : 0;
      ct  = sp ? "R5" : "R1";
      push_w(1'b1, (sp && !c_large) ? 8'h50 : 8'h00, ct);
      push_w(1'b0, col[7:0], ct);
      if (c_large) push_w(1'b0, col[15:8], ct);
      push_w(1'b0, row[7:0], "R3");
      push_w(1'b0, row[15:8], "R2");
      if (c_row3) push_w(1'b0, row[23:16], "R2");
      if (c_large) push_w(1'b1, 8'h30, "R4");
   endtask

   task automatic push_data(int row, bit sp);
      int nb, nx;
      nb = sp ? int'(c_spare) : (c_large ? 2048 : 512);
      nx = c_bus16 ? nb / 2 : nb;
      for (int k = 0; k < nx; k++) begin
         if (c_bus16) dq.push_back({byte_at(row, sp, 2*k+1), byte_at(row, sp, 2*k)});
         else         dq.push_back({8'h00, byte_at(row, sp, k)});
      end
   endtask

   task automatic run_op(int op, int blk, int pg, bit exp_err, bit inject);
      int base, r0;
      bit exp_bad;
      bit got;
      base = blk * int'(c_ppb);
      exp_bad = 0;
      if (op == 2) begin
         push_seq(2, base);
         if (is_bad(base)) exp_bad = 1;
         else begin
            push_seq(2, base + int'(c_ppb) - 1);
            exp_bad = is_bad(base + int'(c_ppb) - 1);
         end
      end else begin
         r0 = base + pg;
         push_seq(op, r0);
         if (!exp_err) push_data(r0, op == 1);
      end
      @(negedge clk);
      start = 1'b1; op_sel = 2'(op); blk_idx = 16'(blk); pg_idx = 8'(pg);
      @(negedge clk);
      start = 1'b0;
      got = 0;
      for (int i = 0; i < 30000; i++) begin
         if (inject && i == 4) begin start = 1'b1; op_sel = 2'd1; blk_idx = 16'd9; end
         if (inject && i == 5) start = 1'b0;
         if (done) begin got = 1; break; end
         @(negedge clk);
      end
      chk(got, "R12", "done seen", int'(got), 1);
      chk(bad_blk == exp_bad, "R8", "bad_blk at done", int'(bad_blk), int'(exp_bad));
      chk(tmo_err == exp_err, "R9", "tmo_err at done", int'(tmo_err), int'(exp_err));
      @(negedge clk);
      chk(!done, "R12", "done single pulse", int'(done), 0);
      repeat (2) @(negedge clk);
      chk(bad_blk == exp_bad && tmo_err == exp_err, "R12", "flags held",
          int'({bad_blk, tmo_err}), int'({exp_bad, exp_err}));
      chk(wq.size() == 0, "R1", "cmd/addr items left", wq.size(), 0);
      chk(dq.size() == 0, "R7", "data items left", dq.size(), 0);
      wq.delete(); dq.delete();
   endtask

   task automatic set_cfg(bit lg, bit r3, bit b16, int sp, int ppb, int mp);
      c_large = lg; c_row3 = r3; c_bus16 = b16;
      c_spare = 7'(sp); c_ppb = 9'(ppb); c_mpos = 6'(mp);
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cyc == 150000 && !finished) begin
         finished = 1;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      start = 0; op_sel = 0; blk_idx = 0; pg_idx = 0;
      set_cfg(0, 0, 0, 16, 32, 5);
      repeat (4) @(negedge clk);
      // R10 reset state
      chk(!busy && !done && !bad_blk && !tmo_err && !rd_valid && !nf_we && !nf_re,
          "R10", "reset outputs", int'({busy, done, bad_blk, tmo_err, rd_valid, nf_we, nf_re}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R2 R3 R7: small page, 2 row cycles, 8-bit
      set_cfg(0, 0, 0, 16, 32, 5);
      run_op(0, 3, 5, 0, 0);
      // R2 R3 R4: large page, 3 row cycles, 8-bit
      set_cfg(1, 1, 0, 64, 128, 0);
      run_op(0, 700, 17, 0, 0);
      // R7: large page, 16-bit
      set_cfg(1, 0, 1, 64, 64, 0);
      run_op(0, 12, 63, 0, 0);
      // R5: spare read small page
      set_cfg(0, 1, 0, 16, 32, 5);
      run_op(1, 40, 2, 0, 0);
      // R5: spare read large page 16-bit
      set_cfg(1, 1, 1, 64, 128, 0);
      run_op(1, 5, 9, 0, 0);
      // R8: good block, 16-bit, odd marker
      set_cfg(0, 0, 1, 16, 32, 5);
      bad_r0 = -1; bad_r1 = -1;
      run_op(2, 6, 0, 0, 0);
      // R8: last page bad only, 16-bit, odd marker
      bad_r0 = 7 * 32 + 31;
      run_op(2, 7, 0, 0, 0);
      // R8: first page bad, large 8-bit, second page not read
      set_cfg(1, 1, 0, 64, 128, 0);
      bad_r0 = 3 * 128; bad_r1 = 3 * 128 + 127;
      run_op(2, 3, 0, 0, 0);
      bad_r0 = -1; bad_r1 = -1;
      // R9: ready never returns within the window
      set_cfg(0, 0, 0, 16, 32, 5);
      t_r = 1000;
      run_op(0, 1, 1, 1, 0);
      t_r = 4;
      // R11: start during an operation is ignored
      run_op(0, 2, 4, 0, 1);
      // R11: op code 3 is ignored
      @(negedge clk);
      start = 1'b1; op_sel = 2'd3;
      @(negedge clk);
      start = 1'b0;
      chk(!busy, "R11", "op 3 start ignored", int'(busy), 0);
      repeat (3) @(negedge clk);
      chk(!busy && wq.size() == 0, "R11", "still idle", int'(busy), 0);

      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule